// File: doc/BRIEF.md
# External Request Command Responder

This block serves external requests on the processor side while the shared system interface is lent to an external agent, which is called slave state here. An arbiter elsewhere pulses `enter_slave_i` when the processor hands the interface over. The responder then samples a command and an address on each cycle in which the active-low `valid_in_n_i` is low. It decodes the request type and either applies it, answers it, or drops it. At the end of each request it decides whether the interface stays with the external agent or goes back to the processor, which is master state here.

Five request kinds are served: word read, word write, snoop, and two null requests. One null request hands secondary-cache ownership back to the processor. The other hands the whole interface back. Reads find nothing readable inside the processor, so each read is answered with zero data and an identifier flagged erroneous. A snoop runs a registered lookup on the cache tags and reports only the line state. A tag miss is reported as invalid. A write is held until its data cycle and is applied only when that cycle is well formed. Otherwise a protocol-error pulse is raised.

Every handover to slave state also gives the external agent ownership of the secondary cache. That ownership lasts until the agent releases it explicitly.

Top module: `ext_req_responder`

## Requirements
- R1: After synchronous reset the block is in master state. `in_slave_o`, `ext_l2_owner_o`, `wr_en_o`, `proto_err_o` and `tag_req_o` are 0. `valid_out_n_o` is 1. `cmd_o` and `ad_o` are 0.
- R2: Requests are accepted only in slave state, and `valid_in_n_i` low is ignored while `in_slave_o` is 0. A command word has `cmd_i[8]`=0, the type in `cmd_i[7:5]` (0 read, 1 write, 2 null, 3 snoop), the null subtype in `cmd_i[4:3]`, and the size in `cmd_i[2:0]`, where 3 means one word. When `enter_slave_i` is high in master state, `in_slave_o` and `ext_l2_owner_o` are 1 from the next cycle on.
- R3: A read sampled at edge E0 is answered in the cycle after edge E0+2. In that cycle `cmd_o` is 0x1E0: bit 8 is identifier, bit 7 is last data, bit 6 is response, bit 5 is erroneous, and the state bits [2:0] are 0. `ad_o` is 0.
- R4: `valid_out_n_o` is low for exactly one cycle per read or snoop. `in_slave_o` falls at the same edge, so the response leaves the block in master state.
- R5: A write command sampled with size 3 captures its address. The next sampled cycle must be an identifier (`cmd_i[8]`=1) with the last-data bit `cmd_i[7]`=1, coherent or not. If it is, `wr_en_o` pulses for one cycle after that edge, with `wr_addr_o` set to the command's address and `wr_data_o` set to the data. `in_slave_o` falls at the same edge.
- R6: If the write size is not 3, or the data cycle is not an identifier with `cmd_i[7]`=1, `proto_err_o` pulses instead of `wr_en_o`, and the interface still returns to master state.
- R7: A snoop on a line that hits in the tags is answered with the read timing of R3. `cmd_o` is 0x1D0 ORed with the 3-bit tag state: identifier, last, response and coherent bit 4 are set, and the erroneous bit is clear. `ad_o` is 0.
- R8: A snoop that misses in the tags reports state 0 (invalid), that is `cmd_o`=0x1D0.
- R9: A null request with subtype 1 clears `ext_l2_owner_o` at the next edge and leaves `in_slave_o` at 1.
- R10: A null request with subtype 0 clears `in_slave_o` at the next edge and leaves `ext_l2_owner_o` unchanged.
- R11: Types 4 to 7, null subtypes 2 and 3, and identifiers in place of a command are ignored. `valid_in_n_i` is also ignored while a read or snoop response is pending.
- R12: Secondary-cache ownership is granted on every entry to slave state. It is kept across returns to master state until a subtype-1 null request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_slave_i | input | 1 | Interface handed to the external agent |
| valid_in_n_i | input | 1 | Active-low: command/identifier and address/data are valid |
| cmd_i | input | 9 | Incoming command or data identifier |
| ad_i | input | AD_W | Incoming address or data |
| tag_req_o | output | 1 | Tag lookup strobe |
| tag_addr_o | output | AD_W | Tag lookup address |
| tag_hit_i | input | 1 | Lookup hit, one cycle after the strobe |
| tag_state_i | input | 3 | Line state on a hit |
| valid_out_n_o | output | 1 | Active-low response valid |
| cmd_o | output | 9 | Response data identifier |
| ad_o | output | AD_W | Response data |
| in_slave_o | output | 1 | Interface currently lent to the external agent |
| ext_l2_owner_o | output | 1 | External agent owns the secondary cache |
| wr_en_o | output | 1 | Write apply pulse |
| wr_addr_o | output | AD_W | Write address |
| wr_data_o | output | AD_W | Write data |
| proto_err_o | output | 1 | Malformed write pulse |

## Verification
The RTL assertions check, on every cycle, that a response strobe lasts one cycle and is raised only from slave state, and that the interface is already back in master state when the response appears. They also check that a write pulse never coincides with an error pulse, and that ownership of the secondary cache is granted whenever slave state begins. Other behaviour can only be shown by the bench's scenarios against its reference model. These are the exact response latency, the identifier values for read, snoop hit and snoop miss, and the write address and data pairing. The same holds for malformed writes and for the null requests, which differ in what they release. Finally, the scenarios show that commands arriving in master state, while a response is pending, or with an unknown type are all ignored.

// File: rtl/erq_pkg.sv
package erq_pkg;
  localparam int CMD_W   = 9;
  localparam int STATE_W = 3;
  localparam int F_IDENT = 8;
  localparam int F_LAST  = 7;
  localparam int F_RESP  = 6;
  localparam int F_ERR   = 5;
  localparam int F_COH   = 4;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_WRITE, K_NULL_SYS, K_NULL_L2, K_SNOOP
  } req_kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_WDATA, S_TURN, S_LOOK
  } ctl_state_e;
endpackage

// File: rtl/erq_cmd_decode.sv
module erq_cmd_decode
  import erq_pkg::*;
#(
  parameter logic [2:0] OP_READ   = 3'd0,
  parameter logic [2:0] OP_WRITE  = 3'd1,
  parameter logic [2:0] OP_NULL   = 3'd2,
  parameter logic [2:0] OP_SNOOP  = 3'd3,
  parameter logic [1:0] NUL_SYS   = 2'd0,
  parameter logic [1:0] NUL_L2    = 2'd1,
  parameter logic [2:0] SIZE_WORD = 3'd3
) (
  input  logic [CMD_W-1:0] cmd_i,
  output req_kind_e        kind_o,
  output logic             is_ident_o,
  output logic             size_word_o,
  output logic             id_last_o
);
  logic [2:0] op;
  logic [1:0] sub;

  assign op          = cmd_i[7:5];
  assign sub         = cmd_i[4:3];
  assign is_ident_o  = cmd_i[F_IDENT];
  assign id_last_o   = cmd_i[F_LAST];
  assign size_word_o = (cmd_i[2:0] == SIZE_WORD);

  always_comb begin
    kind_o = K_NONE;
    if (!is_ident_o) begin
      if (op == OP_READ)       kind_o = K_READ;
      else if (op == OP_WRITE) kind_o = K_WRITE;
      else if (op == OP_SNOOP) kind_o = K_SNOOP;
      else if (op == OP_NULL) begin
        if (sub == NUL_SYS)     kind_o = K_NULL_SYS;
        else if (sub == NUL_L2) kind_o = K_NULL_L2;
      end
    end
  end
endmodule

// File: rtl/erq_ctrl.sv
module erq_ctrl
  import erq_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enter_slave_i,
  input  logic            vin_i,
  input  req_kind_e       kind_i,
  input  logic            is_ident_i,
  input  logic            size_word_i,
  input  logic            id_last_i,
  input  logic [AD_W-1:0] ad_i,
  output logic            in_slave_o,
  output logic            ext_l2_owner_o,
  output logic            tag_req_o,
  output logic [AD_W-1:0] tag_addr_o,
  output logic            wr_en_o,
  output logic [AD_W-1:0] wr_addr_o,
  output logic [AD_W-1:0] wr_data_o,
  output logic            proto_err_o,
  output logic            resp_fire_o,
  output logic            resp_snoop_o
);
  ctl_state_e st;
  logic       wr_ok;
  logic       snoop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= S_IDLE;
      in_slave_o     <= 1'b0;
      ext_l2_owner_o <= 1'b0;
      tag_req_o      <= 1'b0;
      tag_addr_o     <= '0;
      wr_en_o        <= 1'b0;
      wr_addr_o      <= '0;
      wr_data_o      <= '0;
      proto_err_o    <= 1'b0;
      wr_ok          <= 1'b0;
      snoop_q        <= 1'b0;
    end else begin
      tag_req_o   <= 1'b0;
      wr_en_o     <= 1'b0;
      proto_err_o <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!in_slave_o) begin
            if (enter_slave_i) begin
              in_slave_o     <= 1'b1;
              ext_l2_owner_o <= 1'b1;
            end
          end else if (vin_i) begin
            case (kind_i)
              K_READ: begin
                st      <= S_TURN;
                snoop_q <= 1'b0;
              end
              K_SNOOP: begin
                st         <= S_TURN;
                snoop_q    <= 1'b1;
                tag_req_o  <= 1'b1;
                tag_addr_o <= ad_i;
              end
              K_WRITE: begin
                st        <= S_WDATA;
                wr_ok     <= size_word_i;
                wr_addr_o <= ad_i;
              end
              K_NULL_SYS: in_slave_o     <= 1'b0;
              K_NULL_L2:  ext_l2_owner_o <= 1'b0;
              default: ;
            endcase
          end
        end
        S_WDATA: begin
          if (vin_i) begin
            st         <= S_IDLE;
            in_slave_o <= 1'b0;
            if (is_ident_i && id_last_i && wr_ok) begin
              wr_en_o   <= 1'b1;
              wr_data_o <= ad_i;
            end else begin
              proto_err_o <= 1'b1;
            end
          end
        end
        S_TURN: st <= S_LOOK;
        S_LOOK: begin
          st         <= S_IDLE;
          in_slave_o <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign resp_fire_o  = (st == S_LOOK);
  assign resp_snoop_o = snoop_q;

  // R6: a write is either applied or flagged, never both
  a_r6_no_write_with_error: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_o && proto_err_o));

  // R12: cache ownership accompanies each entry to slave state
  a_r12_owner_on_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(in_slave_o) |-> ext_l2_owner_o);

  // R5: writes are only applied out of slave state
  a_r5_write_from_slave: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(in_slave_o));
endmodule

// File: rtl/erq_resp_gen.sv
module erq_resp_gen
  import erq_pkg::*;
#(
  parameter int AD_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire_i,
  input  logic               snoop_i,
  input  logic               tag_hit_i,
  input  logic [STATE_W-1:0] tag_state_i,
  output logic               valid_out_n_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [AD_W-1:0]    ad_o
);
  logic [STATE_W-1:0] line_state;
  logic [CMD_W-1:0]   ident;

  assign line_state = tag_hit_i ? tag_state_i : '0;

  always_comb begin
    ident          = '0;
    ident[F_IDENT] = 1'b1;
    ident[F_LAST]  = 1'b1;
    ident[F_RESP]  = 1'b1;
    if (snoop_i) begin
      ident[F_COH]         = 1'b1;
      ident[STATE_W-1:0]   = line_state;
    end else begin
      ident[F_ERR] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out_n_o <= 1'b1;
      cmd_o         <= '0;
      ad_o          <= '0;
    end else begin
      valid_out_n_o <= !fire_i;
      if (fire_i) begin
        cmd_o <= ident;
        ad_o  <= '0;
      end
    end
  end

  // R4: the response strobe lasts one cycle
  a_r4_single_valid_out: assert property (@(posedge clk) disable iff (rst)
    !valid_out_n_o |=> valid_out_n_o);

  // R3: every response identifier marks identifier, last and response
  a_r3_resp_flags: assert property (@(posedge clk) disable iff (rst)
    !valid_out_n_o |-> (cmd_o[F_IDENT] && cmd_o[F_LAST] && cmd_o[F_RESP]));
endmodule

// File: rtl/ext_req_responder.sv
module ext_req_responder
  import erq_pkg::*;
#(
  parameter int AD_W = 32,
  parameter logic [2:0] OP_READ   = 3'd0,
  parameter logic [2:0] OP_WRITE  = 3'd1,
  parameter logic [2:0] OP_NULL   = 3'd2,
  parameter logic [2:0] OP_SNOOP  = 3'd3,
  parameter logic [1:0] NUL_SYS   = 2'd0,
  parameter logic [1:0] NUL_L2    = 2'd1,
  parameter logic [2:0] SIZE_WORD = 3'd3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enter_slave_i,
  input  logic               valid_in_n_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [AD_W-1:0]    ad_i,
  output logic               tag_req_o,
  output logic [AD_W-1:0]    tag_addr_o,
  input  logic               tag_hit_i,
  input  logic [STATE_W-1:0] tag_state_i,
  output logic               valid_out_n_o,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [AD_W-1:0]    ad_o,
  output logic               in_slave_o,
  output logic               ext_l2_owner_o,
  output logic               wr_en_o,
  output logic [AD_W-1:0]    wr_addr_o,
  output logic [AD_W-1:0]    wr_data_o,
  output logic               proto_err_o
);
  req_kind_e kind;
  logic      is_ident, size_word, id_last;
  logic      resp_fire, resp_snoop;

  erq_cmd_decode #(
    .OP_READ(OP_READ), .OP_WRITE(OP_WRITE), .OP_NULL(OP_NULL),
    .OP_SNOOP(OP_SNOOP), .NUL_SYS(NUL_SYS), .NUL_L2(NUL_L2),
    .SIZE_WORD(SIZE_WORD)
  ) u_dec (
    .cmd_i(cmd_i), .kind_o(kind), .is_ident_o(is_ident),
    .size_word_o(size_word), .id_last_o(id_last)
  );

  erq_ctrl #(.AD_W(AD_W)) u_ctrl (
    .clk(clk), .rst(rst), .enter_slave_i(enter_slave_i),
    .vin_i(!valid_in_n_i), .kind_i(kind), .is_ident_i(is_ident),
    .size_word_i(size_word), .id_last_i(id_last), .ad_i(ad_i),
    .in_slave_o(in_slave_o), .ext_l2_owner_o(ext_l2_owner_o),
    .tag_req_o(tag_req_o), .tag_addr_o(tag_addr_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .proto_err_o(proto_err_o), .resp_fire_o(resp_fire),
    .resp_snoop_o(resp_snoop)
  );

  erq_resp_gen #(.AD_W(AD_W)) u_resp (
    .clk(clk), .rst(rst), .fire_i(resp_fire), .snoop_i(resp_snoop),
    .tag_hit_i(tag_hit_i), .tag_state_i(tag_state_i),
    .valid_out_n_o(valid_out_n_o), .cmd_o(cmd_o), .ad_o(ad_o)
  );

  // R4: a response leaves the interface in master state
  a_r4_resp_returns_master: assert property (@(posedge clk) disable iff (rst)
    !valid_out_n_o |-> !in_slave_o);

  // R2: responses only follow a period in slave state
  a_r2_resp_needs_slave: assert property (@(posedge clk) disable iff (rst)
    !valid_out_n_o |-> $past(in_slave_o));
endmodule

// File: tb/ext_req_responder_tb.sv
module ext_req_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AD_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            enter_slave_i = 1'b0;
  logic            valid_in_n_i = 1'b1;
  logic [8:0]      cmd_i = '0;
  logic [AD_W-1:0] ad_i = '0;
  logic            tag_req_o;
  logic [AD_W-1:0] tag_addr_o;
  logic            tag_hit_i = 1'b0;
  logic [2:0]      tag_state_i = '0;
  logic            valid_out_n_o;
  logic [8:0]      cmd_o;
  logic [AD_W-1:0] ad_o;
  logic            in_slave_o, ext_l2_owner_o, wr_en_o, proto_err_o;
  logic [AD_W-1:0] wr_addr_o, wr_data_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_req_responder u_dut (
    .clk(clk), .rst(rst), .enter_slave_i(enter_slave_i),
    .valid_in_n_i(valid_in_n_i), .cmd_i(cmd_i), .ad_i(ad_i),
    .tag_req_o(tag_req_o), .tag_addr_o(tag_addr_o),
    .tag_hit_i(tag_hit_i), .tag_state_i(tag_state_i),
    .valid_out_n_o(valid_out_n_o), .cmd_o(cmd_o), .ad_o(ad_o),
    .in_slave_o(in_slave_o), .ext_l2_owner_o(ext_l2_owner_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .proto_err_o(proto_err_o)
  );

  // tag store model: hit when address bit 8 is set, state from low bits
  always @(posedge clk) begin
    tag_hit_i   <= tag_addr_o[8];
    tag_state_i <= tag_addr_o[2:0] | 3'b100;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit              m_slave, m_l2, m_vout_n, m_wr, m_err;
  logic [8:0]      m_cmd;
  logic [AD_W-1:0] m_wa, m_wd;
  int              pend;
  bit              m_snp, w_wait, w_ok;
  logic [AD_W-1:0] s_addr, w_addr;

  always @(posedge clk) begin
    if (rst) begin
      m_slave = 0; m_l2 = 0; m_vout_n = 1; m_wr = 0; m_err = 0;
      m_cmd = '0; m_wa = '0; m_wd = '0; pend = -1; w_wait = 0;
    end else begin
      m_vout_n = 1; m_wr = 0; m_err = 0;
      if (pend == 2) pend = 1;
      else if (pend == 1) begin
        m_vout_n = 0;
        m_cmd = m_snp ? (9'h1D0 | (s_addr[8] ? {6'd0, s_addr[2:0] | 3'b100} : 9'd0))
                      : 9'h1E0;
        m_slave = 0;
        pend = -1;
      end else if (w_wait) begin
        if (!valid_in_n_i) begin
          w_wait = 0;
          m_slave = 0;
          if (cmd_i[8] && cmd_i[7] && w_ok) begin
            m_wr = 1; m_wa = w_addr; m_wd = ad_i;
          end else m_err = 1;
        end
      end else if (!m_slave) begin
        if (enter_slave_i) begin m_slave = 1; m_l2 = 1; end
      end else if (!valid_in_n_i && !cmd_i[8]) begin
        case (cmd_i[7:5])
          3'd0: begin pend = 2; m_snp = 0; end
          3'd3: begin pend = 2; m_snp = 1; s_addr = ad_i; end
          3'd1: begin w_wait = 1; w_ok = (cmd_i[2:0] == 3'd3); w_addr = ad_i; end
          3'd2: begin
            if (cmd_i[4:3] == 2'd0) m_slave = 0;
            else if (cmd_i[4:3] == 2'd1) m_l2 = 0;
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(valid_out_n_o == m_vout_n, "R4 valid_out_n", valid_out_n_o, m_vout_n);
      chk(cmd_o == m_cmd, "R3 cmd_o", cmd_o, m_cmd);
      chk(ad_o == '0, "R3 ad_o", ad_o, 0);
      chk(in_slave_o == m_slave, "R2 in_slave", in_slave_o, m_slave);
      chk(ext_l2_owner_o == m_l2, "R12 l2 owner", ext_l2_owner_o, m_l2);
      chk(wr_en_o == m_wr, "R5 wr_en", wr_en_o, m_wr);
      chk(proto_err_o == m_err, "R6 proto_err", proto_err_o, m_err);
      if (m_wr) begin
        chk(wr_addr_o == m_wa, "R5 wr_addr", wr_addr_o, m_wa);
        chk(wr_data_o == m_wd, "R5 wr_data", wr_data_o, m_wd);
      end
    end
  end

  // ---------------- stimulus (entered and left at a negedge) ----------------
  function automatic logic [8:0] mk(input logic [2:0] op, input logic [1:0] sub,
                                    input logic [2:0] sz);
    return {1'b0, op, sub, sz};
  endfunction

  task automatic send(input logic [8:0] c, input logic [AD_W-1:0] a);
    valid_in_n_i = 0; cmd_i = c; ad_i = a;
    @(negedge clk);
    valid_in_n_i = 1; cmd_i = 9'h1FF; ad_i = 32'hDEAD_BEEF;
  endtask

  task automatic enter();
    enter_slave_i = 1;
    @(negedge clk);
    enter_slave_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(valid_out_n_o == 1 && in_slave_o == 0 && ext_l2_owner_o == 0 &&
        wr_en_o == 0 && proto_err_o == 0 && tag_req_o == 0 && cmd_o == 0,
        "R1 reset outputs", {valid_out_n_o, in_slave_o, ext_l2_owner_o}, 3'b100);
    rst = 0;
    idle(1);

    // R2: request in master state is ignored
    send(mk(3'd0, 2'd0, 3'd3), 32'h10);
    idle(3);
    chk(valid_out_n_o == 1, "R2 master ignores read", valid_out_n_o, 1);

    // R2/R12: entry grants slave state and cache ownership
    enter();
    chk(in_slave_o && ext_l2_owner_o, "R12 entry owner", {in_slave_o, ext_l2_owner_o}, 2'b11);

    // R3/R4: read
    send(mk(3'd0, 2'd0, 3'd3), 32'h40);
    idle(1);
    chk(valid_out_n_o == 1, "R3 no early response", valid_out_n_o, 1);
    idle(1);
    chk(valid_out_n_o == 0 && cmd_o == 9'h1E0, "R3 read ident", cmd_o, 9'h1E0);
    chk(in_slave_o == 0, "R4 master after read", in_slave_o, 0);
    idle(1);
    chk(valid_out_n_o == 1, "R4 strobe one cycle", valid_out_n_o, 1);

    // R7: snoop hit, state 5
    enter();
    send(mk(3'd3, 2'd0, 3'd3), 32'h105);
    idle(2);
    chk(valid_out_n_o == 0 && cmd_o == 9'h1D5, "R7 snoop hit", cmd_o, 9'h1D5);

    // R8: snoop miss
    enter();
    send(mk(3'd3, 2'd0, 3'd3), 32'h006);
    idle(2);
    chk(valid_out_n_o == 0 && cmd_o == 9'h1D0, "R8 snoop miss", cmd_o, 9'h1D0);

    // R5: good write
    enter();
    send(mk(3'd1, 2'd0, 3'd3), 32'hA000_0010);
    send(9'h180, 32'h1234_5678);
    chk(wr_en_o && wr_addr_o == 32'hA000_0010 && wr_data_o == 32'h1234_5678,
        "R5 write apply", wr_data_o, 32'h1234_5678);
    chk(in_slave_o == 0, "R5 master after write", in_slave_o, 0);

    // R6: bad size
    enter();
    send(mk(3'd1, 2'd0, 3'd2), 32'h20);
    send(9'h180, 32'h55);
    chk(proto_err_o && !wr_en_o, "R6 bad size", {proto_err_o, wr_en_o}, 2'b10);

    // R6: missing last indication
    enter();
    send(mk(3'd1, 2'd0, 3'd3), 32'h24);
    send(9'h100, 32'h66);
    chk(proto_err_o && !wr_en_o, "R6 no last", {proto_err_o, wr_en_o}, 2'b10);

    // R11: unknown type and null subtype 2 ignored in slave state
    enter();
    send(mk(3'd6, 2'd0, 3'd3), 32'h0);
    send(mk(3'd2, 2'd2, 3'd0), 32'h0);
    send(9'h180, 32'h0);
    idle(3);
    chk(in_slave_o && ext_l2_owner_o && valid_out_n_o, "R11 ignored kinds",
        {in_slave_o, ext_l2_owner_o, valid_out_n_o}, 3'b111);

    // R9: cache release keeps slave state
    send(mk(3'd2, 2'd1, 3'd0), 32'hFFFF_FFFF);
    chk(!ext_l2_owner_o && in_slave_o, "R9 cache release", {ext_l2_owner_o, in_slave_o}, 2'b01);

    // R10: interface release, ownership stays as it was
    send(mk(3'd2, 2'd0, 3'd0), 32'h0);
    chk(!in_slave_o && !ext_l2_owner_o, "R10 interface release", in_slave_o, 0);

    // R12: ownership survives a return to master
    enter();
    send(mk(3'd2, 2'd0, 3'd0), 32'h0);
    chk(!in_slave_o && ext_l2_owner_o, "R12 owner kept", ext_l2_owner_o, 1);

    // R11: request during pending response ignored
    enter();
    send(mk(3'd0, 2'd0, 3'd3), 32'h8);
    send(mk(3'd2, 2'd1, 3'd0), 32'h0);
    idle(1);
    chk(valid_out_n_o == 0 && ext_l2_owner_o, "R11 pending ignores", ext_l2_owner_o, 1);

    idle(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule